// File: doc/BRIEF.md
# Logic Self-Test Controller with Keyed Fault Injection

This block runs a logic built-in self-test on a unit under test. A start request loads a 32-bit linear feedback shift register from a seed. The register then drives one pseudo-random pattern per cycle onto the pattern bus. That bus is the primary input of the unit under test. The unit's response comes back the same cycle and is folded into a 32-bit multiple-input signature register. After a fixed number of patterns, the signature is compared with a golden value, and the block reports pass or fail.

A self-check mode proves that the compare path can detect errors. The mode arms only when a 4-bit key holds the value 1010 and a separate fault-insert bit is set. When armed, gating on the pattern bus holds bit 0 at 0 for every pattern of the run. The generator keeps its normal sequence. The fault therefore passes through the unit under test and into the compactor, and the signature no longer matches the fault-free golden value. In this mode a failing result is the expected outcome.

Top module: `lbist_ctrl`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `busy`, `done`, `fail` and `pat_valid` are 0, `pattern` is 0 and `signature` is 0xFFFFFFFF.
- R2: A `start` pulse seen at a clock edge while idle makes `busy` 1 and clears `done` and `fail` from the next cycle. `pat_valid` is then 1 for exactly PAT_COUNT consecutive cycles. One compare cycle follows, after which `busy` is 0 and `done` is 1.
- R3: The first pattern of a run equals the seed, with a zero seed replaced by 1. Each following pattern is the previous one shifted left by one. The feedback bit enters at bit 0 and is the XOR of bits 31, 21, 1 and 0 of the previous pattern.
- R4: At an accepted start the signature is set to 0xFFFFFFFF. On every cycle with `pat_valid` high it becomes the value shifted left by one, with the XOR of bits 31, 21, 1 and 0 entering bit 0, then XORed with `response`.
- R5: When `done` rises, `fail` is 1 exactly when the signature differs from `golden`. `golden` is sampled in the compare cycle.
- R6: When `key` is 4'b1010 and `fault_ins` is 1 at the accepted start, bit 0 of `pattern` is 0 for every pattern of the run. Bits 31:1 still follow R3, so against a fault-free golden value the run ends with `fail` = 1.
- R7: With any other `key` value, or with `fault_ins` at 0, the pattern bus carries the generator output unchanged.
- R8: `done` and `fail` keep their values until the next accepted start.
- R9: A `start` pulse while `busy` is 1 is ignored. The running sequence, its configuration and its result are unaffected.
- R10: `pattern` is 0 whenever `pat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run (one-cycle pulse) |
| key | input | 4 | Self-check key, captured at start |
| fault_ins | input | 1 | Fault-insert enable, captured at start |
| seed | input | 32 | Generator seed, captured at start |
| golden | input | 32 | Expected signature, used in the compare cycle |
| response | input | 32 | Response of the unit under test to `pattern` |
| pattern | output | 32 | Pattern driven to the unit under test |
| pat_valid | output | 1 | Pattern bus carries a test pattern |
| signature | output | 32 | Current compactor contents |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (sticky) |
| fail | output | 1 | Signature mismatch at the end of the run (sticky) |

## Verification
The assertions rely on three things about the inputs: `start` is a single-cycle pulse, `key` and `fault_ins` are steady at the edge where a start is accepted, and `response` depends only on the current `pattern` within the same cycle. The bench keeps to all three. It changes every input on the falling edge only, drives `start` for exactly one cycle, and computes `response` with a fixed combinational function of `pattern`. A stray `start` is deliberately raised mid-run to exercise the ignore rule. When it is, `key` and `fault_ins` are set to the armed combination, so that an unwanted capture would show up on the pattern bus.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMP  = 2'd2
    } lbist_state_e;

    localparam logic [3:0] SELF_CHECK_KEY = 4'b1010;

    typedef struct packed {
        logic [3:0] key;
        logic       fault_ins;
    } lbist_cfg_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic fail;
    } lbist_status_t;

    function automatic logic inject_armed(input lbist_cfg_t cfg);
        return (cfg.key == SELF_CHECK_KEY) && cfg.fault_ins;
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int unsigned WIDTH = 32,
    parameter logic [WIDTH-1:0] TAP_MASK = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state_q
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] seed_eff;
    logic             feedback;

    assign seed_eff = (seed == '0) ? ONE : seed;
    assign feedback = ^(state_q & TAP_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ONE;
        end else if (load) begin
            state_q <= seed_eff;
        end else if (step) begin
            state_q <= {state_q[WIDTH-2:0], feedback};
        end
    end
endmodule

// File: rtl/lbist_fault_gate.sv
module lbist_fault_gate #(
    parameter int unsigned WIDTH     = 32,
    parameter int unsigned FAULT_BIT = 0
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             valid,
    input  logic             armed,
    output logic [WIDTH-1:0] pattern
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == FAULT_BIT) begin : g_stuck
            assign pattern[i] = valid & raw[i] & ~armed;
        end else begin : g_pass
            assign pattern[i] = valid & raw[i];
        end
    end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int unsigned WIDTH = 32,
    parameter logic [WIDTH-1:0] TAP_MASK = 32'h8020_0003,
    parameter logic [WIDTH-1:0] INIT     = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic [WIDTH-1:0] response,
    output logic [WIDTH-1:0] sig_q
);
    logic [WIDTH-1:0] shifted;

    assign shifted = {sig_q[WIDTH-2:0], ^(sig_q & TAP_MASK)};

    always_ff @(posedge clk) begin
        if (rst || init) begin
            sig_q <= INIT;
        end else if (step) begin
            sig_q <= shifted ^ response;
        end
    end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int unsigned PAT_COUNT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  lbist_cfg_t    cfg_in,
    input  logic          sig_match,
    output logic          load,
    output logic          step,
    output logic          armed,
    output lbist_status_t status
);
    localparam int unsigned CNT_W = (PAT_COUNT > 1) ? $clog2(PAT_COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_COUNT - 1);

    lbist_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             fail_q;
    logic             armed_q;

    assign load  = (state_q == ST_IDLE) && start;
    assign step  = (state_q == ST_RUN);
    assign armed = armed_q;

    always_comb begin
        status.busy = (state_q != ST_IDLE);
        status.done = done_q;
        status.fail = fail_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        armed_q <= inject_armed(cfg_in);
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_CMP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CMP: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    fail_q  <= ~sig_match;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int unsigned PAT_COUNT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  key,
    input  logic        fault_ins,
    input  logic [31:0] seed,
    input  logic [31:0] golden,
    input  logic [31:0] response,
    output logic [31:0] pattern,
    output logic        pat_valid,
    output logic [31:0] signature,
    output logic        busy,
    output logic        done,
    output logic        fail
);
    localparam int unsigned WIDTH = 32;
    localparam logic [WIDTH-1:0] TAPS = 32'h8020_0003;

    lbist_cfg_t       cfg;
    lbist_status_t    status;
    logic             load;
    logic             step;
    logic             armed;
    logic [WIDTH-1:0] raw;

    assign cfg.key       = key;
    assign cfg.fault_ins = fault_ins;

    lbist_seq #(.PAT_COUNT(PAT_COUNT)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg),
        .sig_match(signature == golden),
        .load(load), .step(step), .armed(armed), .status(status)
    );

    lbist_prpg #(.WIDTH(WIDTH), .TAP_MASK(TAPS)) u_prpg (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .seed(seed), .state_q(raw)
    );

    lbist_fault_gate #(.WIDTH(WIDTH), .FAULT_BIT(0)) u_gate (
        .raw(raw), .valid(step), .armed(armed), .pattern(pattern)
    );

    lbist_misr #(.WIDTH(WIDTH), .TAP_MASK(TAPS), .INIT('1)) u_misr (
        .clk(clk), .rst(rst), .init(load), .step(step),
        .response(response), .sig_q(signature)
    );

    assign pat_valid = step;
    assign busy      = status.busy;
    assign done      = status.done;
    assign fail      = status.fail;
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
    parameter int unsigned PAT_COUNT = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [3:0]  key,
    input logic        fault_ins,
    input logic [31:0] pattern,
    input logic        pat_valid,
    input logic        busy,
    input logic        done,
    input logic        fail
);
    logic        start_acc;
    logic        armed_seen;
    int unsigned vcnt;

    assign start_acc = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_seen <= 1'b0;
            vcnt       <= 0;
        end else if (start_acc) begin
            armed_seen <= (key == 4'b1010) && fault_ins;
            vcnt       <= 0;
        end else if (pat_valid) begin
            vcnt <= vcnt + 1;
        end
    end

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_acc |=> (busy && !done && !fail)); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (vcnt == PAT_COUNT)); // R2
    AST_STUCK_BIT0: assert property (@(posedge clk) disable iff (rst)
        (pat_valid && armed_seen) |-> !pattern[0]); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !start_acc) |=> done); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !start_acc) |=> fail); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2
    AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        pat_valid |-> busy); // R2
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pat_valid |-> (pattern == 32'h0)); // R10
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && pat_valid) |=> (busy && !done)); // R9
endmodule

bind lbist_ctrl lbist_ctrl_chk #(.PAT_COUNT(PAT_COUNT)) u_chk (
    .clk(clk), .rst(rst), .start(start), .key(key), .fault_ins(fault_ins),
    .pattern(pattern), .pat_valid(pat_valid), .busy(busy), .done(done),
    .fail(fail)
);

// File: tb/lbist_ctrl_test.sv
module lbist_ctrl_test;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  key = 4'h0;
    logic        fault_ins = 1'b0;
    logic [31:0] seed = 32'h1;
    logic [31:0] golden = 32'h0;
    logic [31:0] response;
    logic [31:0] pattern, signature;
    logic        pat_valid, busy, done, fail;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] shift_fb(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [31:0] unit_fn(input logic [31:0] p);
        return {p[15:0], p[31:16]} ^ (p << 3) ^ 32'h5A5A_1234;
    endfunction

    assign response = unit_fn(pattern);

    lbist_ctrl #(.PAT_COUNT(N)) uut (
        .clk(clk), .rst(rst), .start(start), .key(key), .fault_ins(fault_ins),
        .seed(seed), .golden(golden), .response(response), .pattern(pattern),
        .pat_valid(pat_valid), .signature(signature), .busy(busy),
        .done(done), .fail(fail)
    );

    // behavioural reference: phase 0 idle, 1 running, 2 compare
    int          m_phase = 0;
    int          m_cnt = 0;
    logic [31:0] m_gen = 32'h1;
    logic [31:0] m_sig = 32'hFFFF_FFFF;
    logic        m_arm = 1'b0, m_done = 1'b0, m_fail = 1'b0;

    function automatic logic [31:0] exp_pattern();
        if (m_phase != 1) return 32'h0;
        return m_arm ? (m_gen & 32'hFFFF_FFFE) : m_gen;
    endfunction

    always @(posedge clk) begin
        logic [31:0] p;
        cycles++;
        p = exp_pattern();
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_gen = 32'h1; m_sig = 32'hFFFF_FFFF;
            m_arm = 0; m_done = 0; m_fail = 0;
        end else if (m_phase == 0) begin
            if (start) begin
                m_phase = 1; m_cnt = 0;
                m_gen = (seed == 0) ? 32'h1 : seed;
                m_sig = 32'hFFFF_FFFF;
                m_arm = (key == 4'b1010) && fault_ins;
                m_done = 0; m_fail = 0;
            end
        end else if (m_phase == 1) begin
            m_sig = shift_fb(m_sig) ^ unit_fn(p);
            m_gen = shift_fb(m_gen);
            if (m_cnt == N - 1) m_phase = 2;
            else m_cnt++;
        end else begin
            m_phase = 0; m_done = 1; m_fail = (m_sig != golden);
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(m_arm ? "R6" : "R3", "pattern", pattern, exp_pattern());
            check("R2", "pat_valid", {31'b0, pat_valid}, {31'b0, m_phase == 1});
            check("R2", "busy", {31'b0, busy}, {31'b0, m_phase != 0});
            check("R8", "done", {31'b0, done}, {31'b0, m_done});
            check("R5", "fail", {31'b0, fail}, {31'b0, m_fail});
            check("R4", "signature", signature, m_sig);
        end
    end

    function automatic logic [31:0] clean_sig(input logic [31:0] s0);
        logic [31:0] g = (s0 == 0) ? 32'h1 : s0;
        logic [31:0] s = 32'hFFFF_FFFF;
        for (int i = 0; i < N; i++) begin
            s = shift_fb(s) ^ unit_fn(g);
            g = shift_fb(g);
        end
        return s;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input string tag, input logic [31:0] s, input logic [3:0] k,
                       input logic fi, input logic [31:0] gold, input logic exp_fail);
        @(negedge clk);
        seed = s; key = k; fault_ins = fi; golden = gold;
        pulse_start();
        check("R2", "busy after start", {31'b0, busy}, 32'h1);
        while (busy) @(negedge clk);
        check(tag, "done at end", {31'b0, done}, 32'h1);
        check(tag, "fail at end", {31'b0, fail}, {31'b0, exp_fail});
    endtask

    initial begin
        logic [31:0] g;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", {31'b0, busy}, 32'h0);
        check("R1", "valid in reset", {31'b0, pat_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done", {31'b0, done}, 32'h0);
        check("R1", "fail", {31'b0, fail}, 32'h0);
        check("R1", "pattern", pattern, 32'h0);
        check("R1", "signature", signature, 32'hFFFF_FFFF);
        check("R10", "idle bus", pattern, 32'h0);

        g = clean_sig(32'hACE1_2357);
        run("R5", 32'hACE1_2357, 4'h0, 1'b0, g, 1'b0);
        run("R5", 32'hACE1_2357, 4'h0, 1'b0, g ^ 32'h8, 1'b1);
        // R8: result held through idle cycles
        repeat (5) @(negedge clk);
        check("R8", "fail held", {31'b0, fail}, 32'h1);
        check("R8", "done held", {31'b0, done}, 32'h1);
        run("R6", 32'hACE1_2357, 4'b1010, 1'b1, g, 1'b1);
        run("R7", 32'hACE1_2357, 4'b1011, 1'b1, g, 1'b0);
        run("R7", 32'hACE1_2357, 4'b1010, 1'b0, g, 1'b0);
        g = clean_sig(32'h0);
        run("R3", 32'h0, 4'h0, 1'b0, g, 1'b0);

        // R9: stray start with armed key mid-run must change nothing
        g = clean_sig(32'h1357_9BDF);
        @(negedge clk);
        seed = 32'h1357_9BDF; key = 4'h0; fault_ins = 1'b0; golden = g;
        pulse_start();
        repeat (10) @(negedge clk);
        seed = 32'hDEAD_BEEF; key = 4'b1010; fault_ins = 1'b1;
        pulse_start();
        while (busy) @(negedge clk);
        check("R9", "fail after ignored start", {31'b0, fail}, 32'h0);
        check("R9", "done after ignored start", {31'b0, done}, 32'h1);
        check("R10", "bus quiet after run", pattern, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule